// File: doc/BRIEF.md
# Debug Abstract Command Engine

This block sits between a debugger's register-access port and a hart that runs in a debug loop. The debugger writes a 32-bit command word. The block checks it against the hart's halted state and against the legal register range and access sizes. If the command passes, the block loads a two-word descriptor for the hart, raises a go flag and marks itself busy. The hart clears go when it picks the work up ("going" report). It clears busy by reporting halted once go is low. If the hart traps instead, it sends an exception report.

The block also holds the shared data words and the program-buffer words. Both are locked against debugger access while a command runs. Any failure is kept in a sticky 3-bit error code that software clears with write-1-to-clear. Per-word auto-execute bits let a read or write of a chosen data or buffer word re-run the last command, so block transfers take no extra command writes.

The access port takes one access per cycle and never stalls, so it has no ready signal. Every read gives exactly one `rsp_valid` pulse in the next cycle, and the debugger must accept it. The address map is fixed:

- Data word i is at `0x00+i`.
- Buffer word i is at `0x10+i`.
- The status register is at `0x20`.
- The command register is at `0x21`.
- The auto-execute register is at `0x22`.

Top module: `abs_cmd_engine`

## Requirements
- R1: After reset, busy, the error code (bits 10:8 of status), go and all data and buffer words are zero. Status bits 3:0 read the data-word count and bits 28:24 read the buffer-word count.
- R2: A command whose bits 31:24 are non-zero sets error 2 (not supported) and does not set busy.
- R3: While the error code is non-zero, a command is ignored: busy, go and the error code do not change. A command written while busy sets error 1 (busy).
- R4: A register-access command issued while `hart_halted` is low sets error 4 (halt/resume).
- R5: The command fields are: size in bits 22:20, post-execute in bit 18, transfer in bit 17, write in bit 16, register number in bits 15:0. When transfer is 1, the register number must lie in 0x1000..0x101F and the size must be 2 or 3; otherwise error 2 is set. An accepted command sets busy and go. Descriptor word 0 then holds the operation in bits 31:30 (1 = register to data, 2 = data to register), a 1 in bit 29 for size 3, and the register number minus 0x1000 in bits 4:0. Without transfer, descriptor word 0 is 0.
- R6: Descriptor word 1 is 0 (no-op) when post-execute is set and 1 (break) otherwise.
- R7: A going report clears go. A halted report clears busy only when go is already low.
- R8: An exception report sets error 3 only when the error code is zero after any same-cycle clearing.
- R9: Writing the status register clears each error bit whose bit in bits 10:8 of the write data is 1. Other error bits stay as they were.
- R10: While busy, a debugger write to a data or buffer word leaves the word unchanged, and a read returns 0xFFFFFFFF. A data-word access while busy also sets error 1 if the error code is zero.
- R11: When not busy and the error code is zero, a read or write of data word i re-runs the last command if auto-execute bit i (bit i of register 0x22) is set. A read or write of buffer word i does the same if auto-execute bit 16+i is set.
- R12: Data and buffer words read back what was last written by the debugger or, for data words, by the hart port. Read data appears one cycle after the read request, with `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Debugger access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Register address |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_data | output | 32 | Read data |
| hart_halted | input | 1 | Selected hart is halted |
| rpt_halted | input | 1 | Hart reports entry to the halted loop (pulse) |
| rpt_going | input | 1 | Hart reports it picked up the command (pulse) |
| rpt_exception | input | 1 | Hart reports a trap while running the command (pulse) |
| hart_data_we | input | 1 | Hart writes a data word |
| hart_data_idx | input | 6 | Data word index for the hart write |
| hart_data_wdata | input | 32 | Hart write data |
| go | output | 1 | Command ready for the hart |
| desc0 | output | 32 | Descriptor word 0 (transfer operation) |
| desc1 | output | 32 | Descriptor word 1 (no-op or break) |
| data_words | output | NDATA*32 | All data words, word i at bits 32i+31:32i |
| pbuf_words | output | NPROG*32 | All buffer words, word i at bits 32i+31:32i |

## Verification
The hardest state to reach is the interplay of the completion handshake with the pending error. Busy must survive a halted report that arrives while go is still set. An exception that lands on an already-set error must not overwrite it. Auto-execute must fire only from the idle, error-free state. The bench drives the hart's reports as separate pulses in chosen orders, with reads of the status register in between. It sweeps every size code, the register numbers on both sides of the legal range, and both settings of transfer and post-execute. Each outcome is compared with an arithmetic prediction of the error code and the descriptor words.

// File: rtl/ace_pkg.sv
package ace_pkg;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] DATA_BASE = 6'h00;
  localparam logic [ADDR_W-1:0] PBUF_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] A_STATUS  = 6'h20;
  localparam logic [ADDR_W-1:0] A_CMD     = 6'h21;
  localparam logic [ADDR_W-1:0] A_AUTO    = 6'h22;

  // error codes
  localparam logic [2:0] E_NONE    = 3'd0;
  localparam logic [2:0] E_BUSY    = 3'd1;
  localparam logic [2:0] E_NOTSUP  = 3'd2;
  localparam logic [2:0] E_EXCEPT  = 3'd3;
  localparam logic [2:0] E_HALTRES = 3'd4;

  // legal register window for transfers
  localparam logic [15:0] REG_LO = 16'h1000;
  localparam logic [15:0] REG_HI = 16'h101F;

  // descriptor encodings
  localparam logic [1:0]  OP_FROM_REG = 2'd1;
  localparam logic [1:0]  OP_TO_REG   = 2'd2;
  localparam logic [31:0] DESC_NOP    = 32'h0000_0000;
  localparam logic [31:0] DESC_BREAK  = 32'h0000_0001;

  // status field positions
  localparam int ST_ERR_LSB  = 8;
  localparam int ST_BUSY_BIT = 12;
  localparam int ST_PBUF_LSB = 24;
  localparam int AUTO_PBUF_LSB = 16;
endpackage

// File: rtl/ace_cmd_check.sv
module ace_cmd_check
  import ace_pkg::*;
(
  input  logic [31:0] cmd,
  input  logic        hart_halted,
  output logic [2:0]  verdict,
  output logic [31:0] desc0,
  output logic [31:0] desc1
);
  logic [7:0]  ctype;
  logic [2:0]  size;
  logic        post, xfer, to_reg;
  logic [15:0] regno;
  logic [15:0] reg_off;
  logic        in_range, size_ok;
  logic        unused_bits;

  assign ctype  = cmd[31:24];
  assign size   = cmd[22:20];
  assign post   = cmd[18];
  assign xfer   = cmd[17];
  assign to_reg = cmd[16];
  assign regno  = cmd[15:0];
  assign reg_off = regno - REG_LO;
  assign unused_bits = ^{cmd[23], cmd[19], reg_off[15:5]};

  assign in_range = (regno >= REG_LO) && (regno <= REG_HI);
  assign size_ok  = (size == 3'd2) || (size == 3'd3);

  always_comb begin
    if (ctype != 8'h00)                      verdict = E_NOTSUP;
    else if (!hart_halted)                   verdict = E_HALTRES;
    else if (xfer && !(in_range && size_ok)) verdict = E_NOTSUP;
    else                                     verdict = E_NONE;
  end

  always_comb begin
    if (xfer)
      desc0 = {(to_reg ? OP_TO_REG : OP_FROM_REG), (size == 3'd3), 24'd0, reg_off[4:0]};
    else
      desc0 = DESC_NOP;
    desc1 = post ? DESC_NOP : DESC_BREAK;
  end
endmodule

// File: rtl/ace_wordbank.sv
module ace_wordbank
  import ace_pkg::*;
#(
  parameter int NW        = 2,
  parameter bit HART_PORT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_i,
  input  logic                dbg_we,
  input  logic [ADDR_W-1:0]   dbg_idx,
  input  logic [WORD_W-1:0]   dbg_wdata,
  input  logic                hart_we,
  input  logic [ADDR_W-1:0]   hart_idx,
  input  logic [WORD_W-1:0]   hart_wdata,
  output logic [NW*WORD_W-1:0] words_o
);
  logic [WORD_W-1:0] mem [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (dbg_we && dbg_idx == ADDR_W'(i))
          mem[i] <= dbg_wdata;
        else if (HART_PORT && hart_we && hart_idx == ADDR_W'(i))
          mem[i] <= hart_wdata;
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_flat
    assign words_o[g*WORD_W +: WORD_W] = mem[g];
  end

  // R10: the controller never lets a debugger write through while busy
  p_no_write_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |-> !busy_i);
  // R10: with no hart write, words hold while busy
  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !hart_we) |=> $stable(words_o));
endmodule

// File: rtl/ace_ctrl.sv
module ace_ctrl
  import ace_pkg::*;
#(
  parameter int NDATA = 2,
  parameter int NPROG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [WORD_W-1:0]       acc_wdata,
  input  logic                    hart_halted,
  input  logic                    rpt_halted,
  input  logic                    rpt_going,
  input  logic                    rpt_exception,
  input  logic [NDATA*WORD_W-1:0] data_flat,
  input  logic [NPROG*WORD_W-1:0] pbuf_flat,
  output logic                    data_we,
  output logic [ADDR_W-1:0]       data_idx,
  output logic                    pbuf_we,
  output logic [ADDR_W-1:0]       pbuf_idx,
  output logic                    busy_o,
  output logic                    go_o,
  output logic [WORD_W-1:0]       desc0_o,
  output logic [WORD_W-1:0]       desc1_o,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_data
);
  localparam logic [ADDR_W-1:0] DATA_END = DATA_BASE + ADDR_W'(NDATA);
  localparam logic [ADDR_W-1:0] PBUF_END = PBUF_BASE + ADDR_W'(NPROG);

  logic             busy_q, go_q;
  logic [2:0]       err_q;
  logic [31:0]      cmd_q, desc0_q, desc1_q;
  logic [NDATA-1:0] auto_data_q;
  logic [NPROG-1:0] auto_pbuf_q;

  logic             busy_n, go_n, load_desc;
  logic [2:0]       err_n;
  logic             in_data, in_pbuf, data_acc, pbuf_acc;
  logic             auto_hit, auto_fire, cmd_wr, status_wr, exec;
  logic [31:0]      cmd_eff, rd_val;
  logic [2:0]       verdict;
  logic [31:0]      chk_desc0, chk_desc1;

  assign in_data  = (acc_addr >= DATA_BASE) && (acc_addr < DATA_END);
  assign in_pbuf  = (acc_addr >= PBUF_BASE) && (acc_addr < PBUF_END);
  assign data_acc = acc_valid && in_data;
  assign pbuf_acc = acc_valid && in_pbuf;
  assign data_idx = acc_addr - DATA_BASE;
  assign pbuf_idx = acc_addr - PBUF_BASE;
  assign data_we  = data_acc && acc_write && !busy_q;
  assign pbuf_we  = pbuf_acc && acc_write && !busy_q;

  assign cmd_wr    = acc_valid && acc_write && acc_addr == A_CMD;
  assign status_wr = acc_valid && acc_write && acc_addr == A_STATUS;

  always_comb begin
    auto_hit = 1'b0;
    for (int i = 0; i < NDATA; i++)
      if (data_acc && data_idx == ADDR_W'(i) && auto_data_q[i]) auto_hit = 1'b1;
    for (int i = 0; i < NPROG; i++)
      if (pbuf_acc && pbuf_idx == ADDR_W'(i) && auto_pbuf_q[i]) auto_hit = 1'b1;
  end

  assign auto_fire = auto_hit && !busy_q;
  assign exec      = cmd_wr || auto_fire;
  assign cmd_eff   = cmd_wr ? acc_wdata : cmd_q;

  ace_cmd_check u_check (
    .cmd         (cmd_eff),
    .hart_halted (hart_halted),
    .verdict     (verdict),
    .desc0       (chk_desc0),
    .desc1       (chk_desc1)
  );

  // next-state: hart reports first, debugger actions override, exception last
  always_comb begin
    busy_n    = busy_q;
    go_n      = go_q;
    err_n     = err_q;
    load_desc = 1'b0;
    if (rpt_going) go_n = 1'b0;
    if (rpt_halted && !go_q) busy_n = 1'b0;
    if (status_wr) err_n = err_q & ~acc_wdata[ST_ERR_LSB +: 3];
    if (data_acc && busy_q && err_q == E_NONE) err_n = E_BUSY;
    if (exec && err_q == E_NONE) begin
      if (busy_q)                 err_n = E_BUSY;
      else if (verdict != E_NONE) err_n = verdict;
      else begin
        busy_n    = 1'b1;
        go_n      = 1'b1;
        load_desc = 1'b1;
      end
    end
    if (rpt_exception && err_n == E_NONE) err_n = E_EXCEPT;
  end

  always_comb begin
    rd_val = '0;
    if (in_data) begin
      for (int i = 0; i < NDATA; i++)
        if (data_idx == ADDR_W'(i)) rd_val = data_flat[i*WORD_W +: WORD_W];
      if (busy_q) rd_val = '1;
    end else if (in_pbuf) begin
      for (int i = 0; i < NPROG; i++)
        if (pbuf_idx == ADDR_W'(i)) rd_val = pbuf_flat[i*WORD_W +: WORD_W];
      if (busy_q) rd_val = '1;
    end else if (acc_addr == A_STATUS) begin
      rd_val[3:0]                = 4'(NDATA);
      rd_val[ST_ERR_LSB +: 3]    = err_q;
      rd_val[ST_BUSY_BIT]        = busy_q;
      rd_val[ST_PBUF_LSB +: 5]   = 5'(NPROG);
    end else if (acc_addr == A_AUTO) begin
      rd_val[NDATA-1:0]                 = auto_data_q;
      rd_val[AUTO_PBUF_LSB +: NPROG]    = auto_pbuf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      go_q        <= 1'b0;
      err_q       <= E_NONE;
      cmd_q       <= '0;
      desc0_q     <= '0;
      desc1_q     <= '0;
      auto_data_q <= '0;
      auto_pbuf_q <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      busy_q <= busy_n;
      go_q   <= go_n;
      err_q  <= err_n;
      if (cmd_wr) cmd_q <= acc_wdata;
      if (load_desc) begin
        desc0_q <= chk_desc0;
        desc1_q <= chk_desc1;
      end
      if (acc_valid && acc_write && acc_addr == A_AUTO) begin
        auto_data_q <= acc_wdata[NDATA-1:0];
        auto_pbuf_q <= acc_wdata[AUTO_PBUF_LSB +: NPROG];
      end
      rsp_valid <= acc_valid && !acc_write;
      if (acc_valid && !acc_write) rsp_data <= rd_val;
    end
  end

  assign busy_o  = busy_q;
  assign go_o    = go_q;
  assign desc0_o = desc0_q;
  assign desc1_o = desc1_q;

  // R5: go is only ever up while a command is outstanding
  p_go_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> busy_q);
  // R5: a new command starts only from an error-free state and raises go
  p_issue_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (go_q && $past(err_q) == E_NONE));
  // R7: busy drops only on a halted report seen with go already low
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(rpt_halted && !go_q));
  // R9: a set error changes only through a status write
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != E_NONE && !status_wr) |=> err_q == $past(err_q));
endmodule

// File: rtl/abs_cmd_engine.sv
module abs_cmd_engine
  import ace_pkg::*;
#(
  parameter int NDATA = 2,
  parameter int NPROG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic                    acc_write,
  input  logic [5:0]              acc_addr,
  input  logic [31:0]             acc_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_data,
  input  logic                    hart_halted,
  input  logic                    rpt_halted,
  input  logic                    rpt_going,
  input  logic                    rpt_exception,
  input  logic                    hart_data_we,
  input  logic [5:0]              hart_data_idx,
  input  logic [31:0]             hart_data_wdata,
  output logic                    go,
  output logic [31:0]             desc0,
  output logic [31:0]             desc1,
  output logic [NDATA*32-1:0]     data_words,
  output logic [NPROG*32-1:0]     pbuf_words
);
  logic              busy;
  logic              data_we, pbuf_we;
  logic [ADDR_W-1:0] data_idx, pbuf_idx;

  ace_ctrl #(.NDATA(NDATA), .NPROG(NPROG)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_wdata     (acc_wdata),
    .hart_halted   (hart_halted),
    .rpt_halted    (rpt_halted),
    .rpt_going     (rpt_going),
    .rpt_exception (rpt_exception),
    .data_flat     (data_words),
    .pbuf_flat     (pbuf_words),
    .data_we       (data_we),
    .data_idx      (data_idx),
    .pbuf_we       (pbuf_we),
    .pbuf_idx      (pbuf_idx),
    .busy_o        (busy),
    .go_o          (go),
    .desc0_o       (desc0),
    .desc1_o       (desc1),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );

  ace_wordbank #(.NW(NDATA), .HART_PORT(1'b1)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy),
    .dbg_we     (data_we),
    .dbg_idx    (data_idx),
    .dbg_wdata  (acc_wdata),
    .hart_we    (hart_data_we),
    .hart_idx   (hart_data_idx),
    .hart_wdata (hart_data_wdata),
    .words_o    (data_words)
  );

  ace_wordbank #(.NW(NPROG), .HART_PORT(1'b0)) u_pbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy),
    .dbg_we     (pbuf_we),
    .dbg_idx    (pbuf_idx),
    .dbg_wdata  (acc_wdata),
    .hart_we    (1'b0),
    .hart_idx   ('0),
    .hart_wdata ('0),
    .words_o    (pbuf_words)
  );
endmodule

// File: tb/abs_cmd_engine_bench.sv
`timescale 1ns/1ps
module abs_cmd_engine_bench;
  localparam int NDATA = 2;
  localparam int NPROG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0;
  logic [5:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_data;
  logic hart_halted = 1, rpt_halted = 0, rpt_going = 0, rpt_exception = 0;
  logic hart_data_we = 0;
  logic [5:0] hart_data_idx = '0;
  logic [31:0] hart_data_wdata = '0;
  logic go;
  logic [31:0] desc0, desc1;
  logic [NDATA*32-1:0] data_words;
  logic [NPROG*32-1:0] pbuf_words;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  abs_cmd_engine #(.NDATA(NDATA), .NPROG(NPROG)) u_abs_cmd_engine (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .hart_halted(hart_halted), .rpt_halted(rpt_halted),
    .rpt_going(rpt_going), .rpt_exception(rpt_exception),
    .hart_data_we(hart_data_we), .hart_data_idx(hart_data_idx),
    .hart_data_wdata(hart_data_wdata), .go(go), .desc0(desc0), .desc1(desc1),
    .data_words(data_words), .pbuf_words(pbuf_words)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a;
    @(negedge clk);
    acc_valid = 0;
    d = rsp_data;
    if (!rsp_valid) begin
      n_chk++; n_fail++;
      $display("FAIL R12 actual=%h expected=%h (rsp_valid)", rsp_valid, 1);
    end
  endtask

  task automatic pulse_going();
    @(negedge clk); rpt_going = 1; @(negedge clk); rpt_going = 0;
  endtask
  task automatic pulse_halted();
    @(negedge clk); rpt_halted = 1; @(negedge clk); rpt_halted = 0;
  endtask
  task automatic pulse_exc();
    @(negedge clk); rpt_exception = 1; @(negedge clk); rpt_exception = 0;
  endtask

  // returns {busy, err}
  task automatic status(output logic busy, output logic [2:0] err);
    logic [31:0] s;
    rd(6'h20, s);
    busy = s[12]; err = s[10:8];
  endtask

  task automatic finish_cmd();
    pulse_going();
    pulse_halted();
  endtask

  function automatic logic [31:0] mk_cmd(input logic [7:0] t, input logic [2:0] sz,
      input bit pe, input bit xf, input bit wb, input logic [15:0] rn);
    return {t, 1'b0, sz, 1'b0, pe, xf, wb, rn};
  endfunction

  localparam logic [31:0] GOOD = {8'h00, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1003};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic b; logic [2:0] e; logic [31:0] d;
    logic [15:0] rnums [5];
    rnums[0] = 16'h0FFF; rnums[1] = 16'h1000; rnums[2] = 16'h1005;
    rnums[3] = 16'h101F; rnums[4] = 16'h1020;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(6'h20, d);
    chk(d == 32'h0400_0002, "R1 status", d, 32'h0400_0002);
    chk(go == 0, "R1 go", {31'd0, go}, 0);
    chk(data_words == '0 && pbuf_words == '0, "R1 words", data_words[31:0], 0);

    // R12 storage and readback
    for (int i = 0; i < NDATA; i++) wr(6'(i), 32'hA500_0000 + 32'(i));
    for (int i = 0; i < NPROG; i++) wr(6'h10 + 6'(i), 32'h5A00_0010 + 32'(i));
    for (int i = 0; i < NDATA; i++) begin
      rd(6'(i), d);
      chk(d == 32'hA500_0000 + 32'(i), "R12 data", d, 32'hA500_0000 + 32'(i));
    end
    for (int i = 0; i < NPROG; i++) begin
      rd(6'h10 + 6'(i), d);
      chk(d == 32'h5A00_0010 + 32'(i), "R12 pbuf", d, 32'h5A00_0010 + 32'(i));
    end
    @(negedge clk); hart_data_we = 1; hart_data_idx = 6'd1; hart_data_wdata = 32'hC0DE_0001;
    @(negedge clk); hart_data_we = 0;
    rd(6'd1, d);
    chk(d == 32'hC0DE_0001, "R12 hart write", d, 32'hC0DE_0001);

    // R2 non-zero command type
    foreach (rnums[k]) begin end
    for (int t = 1; t < 256; t += 127) begin
      wr(6'h21, mk_cmd(8'(t), 3'd2, 0, 1, 0, 16'h1000));
      status(b, e);
      chk(e == 3'd2 && !b, "R2 type", {28'd0, b, e}, 32'h2);
      wr(6'h20, 32'h700);
    end

    // R4 hart not halted
    hart_halted = 0;
    wr(6'h21, GOOD);
    status(b, e);
    chk(e == 3'd4 && !b, "R4 haltresume", {28'd0, b, e}, 32'h4);
    hart_halted = 1;

    // R3 command ignored with pending error
    wr(6'h21, GOOD);
    status(b, e);
    chk(e == 3'd4 && !b && !go, "R3 ignored", {27'd0, go, b, e}, 32'h4);
    // R9 partial clear: 100 with 011 written stays 100
    wr(6'h20, 32'h300);
    status(b, e);
    chk(e == 3'd4, "R9 keep", {29'd0, e}, 4);
    wr(6'h20, 32'h400);
    status(b, e);
    chk(e == 3'd0, "R9 clear", {29'd0, e}, 0);

    // R5/R6 sweep over sizes, register numbers, transfer, post-execute
    for (int sz = 0; sz < 8; sz++)
      for (int ri = 0; ri < 5; ri++)
        for (int xf = 0; xf < 2; xf++)
          for (int pe = 0; pe < 2; pe++) begin
            logic [15:0] rn; bit wb; bit ok; logic [31:0] ed0, ed1;
            rn = rnums[ri];
            wb = ri[0];
            ok = (xf == 0) || (rn >= 16'h1000 && rn <= 16'h101F && (sz == 2 || sz == 3));
            wr(6'h21, mk_cmd(8'h00, 3'(sz), pe[0], xf[0], wb, rn));
            status(b, e);
            chk(e == (ok ? 3'd0 : 3'd2) && b == ok, "R5 verdict", {28'd0, b, e},
                ok ? 32'h8 : 32'h2);
            if (ok) begin
              ed0 = xf ? {(wb ? 2'd2 : 2'd1), (sz == 3), 24'd0, rn[4:0]} : 32'h0;
              ed1 = pe ? 32'h0 : 32'h1;
              chk(desc0 == ed0 && go, "R5 desc0", desc0, ed0);
              chk(desc1 == ed1, "R6 desc1", desc1, ed1);
              pulse_halted(); // go still set: busy must hold
              status(b, e);
              chk(b == 1, "R7 halted with go", {31'd0, b}, 1);
              pulse_going();
              chk(go == 0, "R7 going", {31'd0, go}, 0);
              pulse_halted();
              status(b, e);
              chk(b == 0, "R7 done", {31'd0, b}, 0);
            end else begin
              wr(6'h20, 32'h700);
            end
          end

    // R3 command while busy
    wr(6'h21, GOOD);
    wr(6'h21, GOOD);
    status(b, e);
    chk(e == 3'd1 && b, "R3 busy", {28'd0, b, e}, 32'h9);

    // R10 accesses while busy (error already set: stays 1)
    d = data_words[31:0];
    wr(6'd0, 32'hDEAD_BEEF);
    chk(data_words[31:0] == d, "R10 data hold", data_words[31:0], d);
    wr(6'h11, 32'hDEAD_BEEF);
    chk(pbuf_words[63:32] == 32'h5A00_0011, "R10 pbuf hold", pbuf_words[63:32], 32'h5A00_0011);
    rd(6'd1, d);
    chk(d == 32'hFFFF_FFFF, "R10 read ones", d, 32'hFFFF_FFFF);
    rd(6'h12, d);
    chk(d == 32'hFFFF_FFFF, "R10 pbuf ones", d, 32'hFFFF_FFFF);
    wr(6'h20, 32'h700);
    wr(6'd0, 32'h1234_5678);
    status(b, e);
    chk(e == 3'd1, "R10 sets busy err", {29'd0, e}, 1);
    wr(6'h20, 32'h700);

    // R8 exception during command, then clean finish
    pulse_going();
    pulse_exc();
    status(b, e);
    chk(e == 3'd3, "R8 exception", {29'd0, e}, 3);
    pulse_halted();
    wr(6'h20, 32'h100); // 011 & ~001 = 010
    status(b, e);
    chk(e == 3'd2 && !b, "R9 partial", {28'd0, b, e}, 2);
    pulse_exc();
    status(b, e);
    chk(e == 3'd2, "R8 no overwrite", {29'd0, e}, 2);
    wr(6'h20, 32'h700);

    // R11 auto-execute
    wr(6'h22, 32'h0004_0001); // data0, pbuf2
    rd(6'h22, d);
    chk(d == 32'h0004_0001, "R11 auto reg", d, 32'h0004_0001);
    wr(6'd1, 32'h1);
    status(b, e);
    chk(!b, "R11 no bit", {31'd0, b}, 0);
    wr(6'd0, 32'h7777_0000);
    status(b, e);
    chk(b && data_words[31:0] == 32'h7777_0000, "R11 data auto", {31'd0, b}, 1);
    finish_cmd();
    rd(6'h12, d);
    chk(d == 32'h5A00_0012, "R11 pbuf read val", d, 32'h5A00_0012);
    status(b, e);
    chk(b, "R11 pbuf auto", {31'd0, b}, 1);
    finish_cmd();
    rd(6'h11, d);
    status(b, e);
    chk(!b, "R11 pbuf no bit", {31'd0, b}, 0);
    hart_halted = 0;
    wr(6'd0, 32'h0);
    status(b, e);
    chk(e == 3'd4 && !b, "R11 rerun checks", {28'd0, b, e}, 4);
    hart_halted = 1;
    wr(6'd0, 32'h0);
    status(b, e);
    chk(e == 3'd4 && !b, "R11 blocked by error", {28'd0, b, e}, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule